// File: doc/BRIEF.md
# Banked Clock Fanout Controller

This block takes three candidate reference clocks, picks one, and fans it out to sixteen outputs grouped in four banks of five, three, three and five. Each bank runs either at the reference rate or at half of it. A stop control parks every output low without cutting a pulse short, and a two-bit code puts chosen banks into high impedance. The high-impedance state is modelled as one drive-enable signal per output, for the pad ring to consume.

The reference inputs are treated as waveforms and oversampled by a faster core clock `clk`. One register stage captures the selected reference. One shared toggle register makes the half-rate wave. A final register stage per output forms the common retiming point, so every bank is launched from the same edge. Mode changes and stop entry or release are applied only in a window where both the full-rate and half-rate waves are low. That window is the first core cycle in which the selected reference samples low while the half-rate wave is low. There is no data stream, so every pin is a plain level control or a clock waveform.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: Output bits are laid out by bank: bank A drives `q_out[4:0]`, B `q_out[7:5]`, C `q_out[10:8]` and D `q_out[15:11]`, and all bits of one bank carry the same waveform.
- R2: With `use_se`=1 the single-ended input `se_clk` is the reference. With `use_se`=0, `diff_pick`=0 selects `diff_clk0` and `diff_pick`=1 selects `diff_clk1`.
- R3: Bit b of `div2_sel` (bit 0 bank A, 1 B, 2 C, 3 D) set to 0 gives that bank one rising edge per reference rising edge. Set to 1, it gives one rising edge per two reference rising edges, each high pulse lasting one full reference period.
- R4: Every output rising edge appears exactly two `clk` cycles after the reference is first sampled high, so half-rate rising edges coincide with full-rate rising edges.
- R5: While `stop_req` is held, all outputs go low within one half-rate period plus two cycles and stay low. Entry and release happen only in the common low window.
- R6: After stop release, the first rising edge of every bank, full-rate or half-rate, occurs in the same cycle.
- R7: A change of `div2_sel` takes effect only in the common low window. No output high pulse lasts other than H or 2H cycles, where H is the reference half period in `clk` cycles.
- R8: `hiz_code` (bit 1 first, bit 0 second) decodes as follows. 00 enables every bank. 01 enables only A and D. 10 enables only A and B. 11 enables none. `q_drv_en` is 1 for each enabled output.
- R9: `q_drv_en` follows `hiz_code` combinationally, with no clock edge needed, whatever the state of `stop_req` or the outputs.
- R10: After reset, all outputs are low, all banks are at full rate and running, and with all controls at 0 the block forwards `diff_clk0` to every bank with all drive enables high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| diff_clk0 | input | 1 | First differential-class reference (true leg) |
| diff_clk1 | input | 1 | Second differential-class reference (true leg) |
| se_clk | input | 1 | Single-ended reference |
| use_se | input | 1 | 1 selects the single-ended reference |
| diff_pick | input | 1 | Chooses between the two differential references |
| div2_sel | input | 4 | Per-bank half-rate select |
| stop_req | input | 1 | Park all outputs low |
| hiz_code | input | 2 | Bank high-impedance code |
| q_out | output | 16 | Bank clock outputs |
| q_drv_en | output | 16 | Per-output drive enable |

## Verification
The three references run with distinct half periods of 3, 5 and 4 cycles. Counting rising edges per bank over a fixed window therefore shows at once whether the right source was routed and whether each bank runs at full or half rate. Mixed per-bank rate masks show whether half-rate edges stay aligned with full-rate edges. Stop pulses and rate changes applied at random phases expose any truncated pulse through the pulse-width monitor. All four high-impedance codes, including codes changed while stopped, separate the nonlinear bank decode from a simple thermometer.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_A = 0;
  localparam int BANK_B = 1;
  localparam int BANK_C = 2;
  localparam int BANK_D = 3;

  typedef logic [NUM_BANKS-1:0] bank_mask_t;

  function automatic int bank_offset(input int idx, input int wa, input int wb, input int wc);
    int off;
    off = 0;
    if (idx > 0) off += wa;
    if (idx > 1) off += wb;
    if (idx > 2) off += wc;
    return off;
  endfunction
endpackage

// File: rtl/cf_src_select.sv
module cf_src_select (
  input  logic clk,
  input  logic rst_n,
  input  logic diff_clk0,
  input  logic diff_clk1,
  input  logic se_clk,
  input  logic use_se,
  input  logic diff_pick,
  output logic ref_raw,
  output logic ref_q
);
  logic diff_sel;

  always_comb begin
    diff_sel = diff_pick ? diff_clk1 : diff_clk0;
    ref_raw  = use_se ? se_clk : diff_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_raw;
  end
endmodule

// File: rtl/cf_phase_gen.sv
module cf_phase_gen
  import clkfan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_raw,
  input  logic       ref_q,
  input  logic       stop_req,
  input  bank_mask_t div2_sel,
  output logic       tgl_q,
  output logic       run_q,
  output bank_mask_t div_eff_q
);
  logic rise_ev;
  logic low_win;

  always_comb begin
    rise_ev = ref_raw & ~ref_q;
    low_win = ~ref_raw & ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b1;
      div_eff_q <= '0;
    end else if (low_win) begin
      run_q     <= ~stop_req;
      div_eff_q <= div2_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tgl_q <= 1'b0;
    else if (!run_q)  tgl_q <= 1'b0;
    else if (rise_ev) tgl_q <= ~tgl_q;
  end
endmodule

// File: rtl/cf_bank_drive.sv
module cf_bank_drive #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         ref_q,
  input  logic         tgl_q,
  input  logic         div2,
  output logic [W-1:0] q
);
  logic wave;

  always_comb wave = run & (div2 ? tgl_q : ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {W{wave}};
  end
endmodule

// File: rtl/cf_hiz_decode.sv
module cf_hiz_decode
  import clkfan_pkg::*;
(
  input  logic [1:0] hiz_code,
  output bank_mask_t bank_en
);
  logic first_b;
  logic second_b;

  always_comb begin
    first_b  = hiz_code[1];
    second_b = hiz_code[0];
    bank_en[BANK_A] = ~(first_b & second_b);
    bank_en[BANK_B] = ~second_b;
    bank_en[BANK_C] = ~(first_b | second_b);
    bank_en[BANK_D] = ~first_b;
  end
endmodule

// File: rtl/clk_fanout_ctrl.sv
module clk_fanout_ctrl
  import clkfan_pkg::*;
#(
  parameter int A_W = 5,
  parameter int B_W = 3,
  parameter int C_W = 3,
  parameter int D_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       diff_clk0,
  input  logic                       diff_clk1,
  input  logic                       se_clk,
  input  logic                       use_se,
  input  logic                       diff_pick,
  input  logic [3:0]                 div2_sel,
  input  logic                       stop_req,
  input  logic [1:0]                 hiz_code,
  output logic [A_W+B_W+C_W+D_W-1:0] q_out,
  output logic [A_W+B_W+C_W+D_W-1:0] q_drv_en
);
  localparam int BW [NUM_BANKS] = '{A_W, B_W, C_W, D_W};

  logic       ref_raw;
  logic       ref_q;
  logic       tgl_q;
  logic       run_q;
  bank_mask_t div_eff_q;
  bank_mask_t bank_en;

  cf_src_select u_src (
    .clk(clk), .rst_n(rst_n),
    .diff_clk0(diff_clk0), .diff_clk1(diff_clk1), .se_clk(se_clk),
    .use_se(use_se), .diff_pick(diff_pick),
    .ref_raw(ref_raw), .ref_q(ref_q)
  );

  cf_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n),
    .ref_raw(ref_raw), .ref_q(ref_q),
    .stop_req(stop_req), .div2_sel(div2_sel),
    .tgl_q(tgl_q), .run_q(run_q), .div_eff_q(div_eff_q)
  );

  cf_hiz_decode u_hiz (
    .hiz_code(hiz_code),
    .bank_en(bank_en)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam int OFF = bank_offset(g, A_W, B_W, C_W);
    cf_bank_drive #(.W(BW[g])) u_drive (
      .clk(clk), .rst_n(rst_n),
      .run(run_q), .ref_q(ref_q), .tgl_q(tgl_q),
      .div2(div_eff_q[g]),
      .q(q_out[OFF +: BW[g]])
    );
    assign q_drv_en[OFF +: BW[g]] = {BW[g]{bank_en[g]}};
  end
endmodule

// File: rtl/clk_fanout_ctrl_chk.sv
module clk_fanout_ctrl_chk #(
  parameter int A_W = 5,
  parameter int B_W = 3,
  parameter int C_W = 3,
  parameter int D_W = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       stop_req,
  input logic [1:0]                 hiz_code,
  input logic [A_W+B_W+C_W+D_W-1:0] q_out,
  input logic [A_W+B_W+C_W+D_W-1:0] q_drv_en,
  input logic                       ref_q,
  input logic                       run_q,
  input logic [3:0]                 div_eff_q
);
  localparam int OFF_B = A_W;
  localparam int OFF_C = A_W + B_W;

  // R4
  rise_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(q_out & ~$past(q_out))) |-> ($past(ref_q) && !$past(ref_q, 2)));

  // R5
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (q_out == '0));

  // R7
  mode_switch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_eff_q) |=> (q_out == '0));

  // R8
  bank_c_implies_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_drv_en[OFF_C] |-> (&q_drv_en));

  // R8
  bank_b_implies_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_drv_en[OFF_B] |-> q_drv_en[0]);

  // R9
  stop_no_hiz_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stop_req) && $stable(hiz_code)) |-> $stable(q_drv_en));
endmodule

bind clk_fanout_ctrl clk_fanout_ctrl_chk #(.A_W(A_W), .B_W(B_W), .C_W(C_W), .D_W(D_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .hiz_code(hiz_code),
  .q_out(q_out), .q_drv_en(q_drv_en),
  .ref_q(ref_q), .run_q(run_q), .div_eff_q(div_eff_q)
);

// File: tb/clk_fanout_ctrl_bench.sv
module clk_fanout_ctrl_bench;
  localparam int H0 = 3;
  localparam int H1 = 5;
  localparam int HS = 4;
  localparam int FIRST [4] = '{0, 5, 8, 11};
  localparam int WIDTH [4] = '{5, 3, 3, 5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d0 = 1'b0, d1 = 1'b0, se = 1'b0;
  logic use_se = 1'b0, pick = 1'b0, stop = 1'b0;
  logic [3:0] div2 = 4'b0;
  logic [1:0] hiz = 2'b0;
  logic [15:0] q, en;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int src_rise_cyc = -100;
  bit mon_en = 1'b0;
  logic sel_prev = 1'b0;
  logic [15:0] q_prev = '0;
  int hi_len [16];
  bit armed [16];

  clk_fanout_ctrl u_clk_fanout_ctrl (
    .clk(clk), .rst_n(rst_n), .diff_clk0(d0), .diff_clk1(d1), .se_clk(se),
    .use_se(use_se), .diff_pick(pick), .div2_sel(div2), .stop_req(stop),
    .hiz_code(hiz), .q_out(q), .q_drv_en(en)
  );

  initial forever #4 clk = ~clk;

  initial forever begin repeat (H0) @(posedge clk); #1 d0 = ~d0; end
  initial forever begin repeat (H1) @(posedge clk); #1 d1 = ~d1; end
  initial forever begin repeat (HS) @(posedge clk); #1 se = ~se; end

  function automatic logic sel_src();
    return use_se ? se : (pick ? d1 : d0);
  endfunction

  function automatic int cur_h();
    return use_se ? HS : (pick ? H1 : H0);
  endfunction

  function automatic logic [15:0] exp_en(input logic [1:0] c);
    case (c)
      2'b00:   return 16'hFFFF;
      2'b01:   return 16'hF81F;
      2'b10:   return 16'h00FF;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // glitch, latency and bank-uniformity monitor
  always @(negedge clk) begin
    logic s;
    cyc++;
    s = sel_src();
    if (s && !sel_prev) src_rise_cyc = cyc;
    sel_prev = s;
    if (mon_en) begin
      for (int b = 0; b < 4; b++)
        for (int k = 1; k < WIDTH[b]; k++)
          if (q[FIRST[b]+k] !== q[FIRST[b]]) check(0, "R1 bank bits differ", q[FIRST[b]+k], q[FIRST[b]]);
    end
    for (int k = 0; k < 16; k++) begin
      if (!mon_en) armed[k] = 1'b0;
      if (q[k] && !q_prev[k]) begin
        if (mon_en) begin
          check(cyc - src_rise_cyc == 2, "R4 rise latency", cyc - src_rise_cyc, 2);
          armed[k] = 1'b1;
        end
        hi_len[k] = 0;
      end
      if (q[k]) hi_len[k]++;
      if (!q[k] && q_prev[k] && armed[k] && mon_en)
        check(hi_len[k] == cur_h() || hi_len[k] == 2*cur_h(), "R7 high pulse width", hi_len[k], cur_h());
    end
    q_prev = q;
  end

  task automatic switch_src(input logic se_v, input logic pick_v);
    mon_en = 1'b0;
    @(negedge clk);
    use_se = se_v;
    pick = pick_v;
    repeat (40) @(negedge clk);
    mon_en = 1'b1;
  endtask

  task automatic measure_rates(input int win, input string tag);
    int rc;
    int oc [4];
    logic sp;
    logic [15:0] qp;
    rc = 0;
    for (int b = 0; b < 4; b++) oc[b] = 0;
    sp = sel_src();
    qp = q;
    repeat (win) begin
      @(negedge clk);
      if (sel_src() && !sp) rc++;
      for (int b = 0; b < 4; b++) if (q[FIRST[b]] && !qp[FIRST[b]]) oc[b]++;
      sp = sel_src();
      qp = q;
    end
    for (int b = 0; b < 4; b++) begin
      if (div2[b]) check((2*oc[b] - rc <= 2) && (rc - 2*oc[b] <= 2), {tag, " R3 half rate"}, oc[b], rc/2);
      else         check((oc[b] - rc <= 1) && (rc - oc[b] <= 1), {tag, " R2 R3 full rate"}, oc[b], rc);
    end
  endtask

  initial begin
    #(8*150000);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int first_r [4];
    void'($urandom(32'h1F2E3D4C));
    for (int k = 0; k < 16; k++) begin hi_len[k] = 0; armed[k] = 1'b0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(q == 16'h0, "R10 outputs low in reset", q, 0);
    check(en == 16'hFFFF, "R10 drive enables", en, 16'hFFFF);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_en = 1'b1;
    // R10 defaults forward diff_clk0 at full rate
    measure_rates(240, "R10 defaults");

    // R2 each source with mixed rates
    div2 = 4'b0110;
    switch_src(1'b0, 1'b0); measure_rates(240, "R2 diff0");
    switch_src(1'b0, 1'b1); measure_rates(240, "R2 diff1");
    switch_src(1'b1, 1'b0); measure_rates(240, "R2 single-ended");
    div2 = 4'b1001;
    repeat (30) @(negedge clk);
    measure_rates(240, "R3 swapped mask");

    // R8 R9 all codes, asynchronous
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #1 hiz = c[1:0]; #1;
      check(en == exp_en(c[1:0]), "R8 R9 hiz decode", en, exp_en(c[1:0]));
    end

    // R5 stop, R9 enables unaffected, R6 aligned resume
    @(negedge clk); hiz = 2'b01; stop = 1'b1;
    repeat (2*2*HS + 4) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (q != 16'h0) check(0, "R5 stopped low", q, 0);
    end
    check(q == 16'h0, "R5 stopped low", q, 0);
    check(en == exp_en(2'b01), "R9 enables while stopped", en, exp_en(2'b01));
    #1 hiz = 2'b10; #1;
    check(en == exp_en(2'b10), "R9 decode while stopped", en, exp_en(2'b10));
    div2 = 4'b1010;
    repeat (20) @(negedge clk);
    stop = 1'b0;
    for (int b = 0; b < 4; b++) first_r[b] = -1;
    begin
      logic [15:0] qp;
      qp = q;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        for (int b = 0; b < 4; b++)
          if (first_r[b] < 0 && q[FIRST[b]] && !qp[FIRST[b]]) first_r[b] = cyc;
        qp = q;
      end
    end
    for (int b = 1; b < 4; b++)
      check(first_r[b] == first_r[0] && first_r[0] > 0, "R6 aligned resume", first_r[b], first_r[0]);
    measure_rates(160, "R5 after release");

    // random phase changes
    for (int it = 0; it < 40; it++) begin
      case ($urandom % 4)
        0: begin @(negedge clk); #($urandom % 7 + 1); div2 = 4'($urandom); end
        1: begin
             @(negedge clk); stop = 1'b1;
             repeat (30) @(negedge clk);
             check(q == 16'h0, "R5 random stop", q, 0);
             stop = 1'b0;
           end
        2: begin
             @(negedge clk); #1 hiz = 2'($urandom); #1;
             check(en == exp_en(hiz), "R8 random code", en, exp_en(hiz));
           end
        default: switch_src(1'($urandom), 1'($urandom));
      endcase
      repeat (20 + $urandom % 40) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    measure_rates(240, "R3 final");
    finish_run();
  end
endmodule